// File: doc/BRIEF.md
# Signed-Count Shifter with Overflow Flags

This unit is the shift stage of a DSP datapath. It shifts one selected 16-bit half of a 32-bit operand, the whole 32-bit word, or two packed 16-bit lanes side by side. The shift amount comes from one of two sources. The first is a 6-bit two's-complement count, where zero or a negative value requests an arithmetic right shift and a positive value requests a left shift. The second is a 5-bit immediate. Its values above 16 encode a left shift as an offset from 16, and the rest encode a right shift directly.

A left shift counts as an overflow when the sign bit of a lane differs before and after the shift. Each overflow raises a per-operation flag and a sticky flag. Only a dedicated clear input takes the sticky flag down. For register counts there is an optional saturating mode: an overflowing left shift then clamps to the largest positive or largest negative value of the lane width. The result and the per-operation flag are registered when a valid strobe is seen, and they hold their values until the next valid operation.

Top module: `shift_ovf_unit`

## Requirements
- R1: After reset, result_o is 0 and ovf_o and ovf_sticky_o are both 0.
- R2: With imm_sel_i = 0, count_i is a 6-bit two's-complement count in the range -32 to +31.
- R3: A count of zero or below gives an arithmetic right shift by its magnitude. A magnitude equal to or greater than the lane width fills the lane with its sign bit.
- R4: A positive count gives a left shift. A left shift by the lane width or more gives zero when saturation is off.
- R5: A left shift sets ovf_o when the lane's top bit differs between the operand and the unsaturated shifted value. A right shift never sets ovf_o.
- R6: Every overflowing operation sets ovf_sticky_o. The sticky flag stays set until sticky_clr_i is high at a clock edge. If an overflowing operation and a clear occur in the same cycle, the set takes priority.
- R7: ovf_o reflects only the most recent valid operation, so a valid operation that does not overflow clears it.
- R8: When width_sel_i[1] = 1 (dual lanes), the two 16-bit lanes shift independently by the same amount. Lane 1 goes to bits 31:16 and lane 0 to bits 15:0, and ovf_o is set if either lane overflows.
- R9: width_sel_i = 2'b01 shifts the full 32-bit word and uses bit 31 as the sign bit for overflow.
- R10: width_sel_i = 2'b00 shifts one half. half_sel_i = 0 selects operand bits 15:0 and half_sel_i = 1 selects bits 31:16. The result is placed in bits 15:0 and bits 31:16 are 0.
- R11: With imm_sel_i = 1, an imm_i value greater than 16 means a left shift by 16 minus imm_i[3:0]. Any other value means an arithmetic right shift by imm_i. count_i is ignored in this form.
- R12: With sat_i = 1 and a register count, an overflowing left shift gives 0x7FFF... for a non-negative operand lane and 0x8000... for a negative one, and ovf_o is still set. sat_i has no effect in the immediate form.
- R13: While valid_i is low, result_o and ovf_o keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Registers a new result and flag update |
| width_sel_i | input | 2 | 00 half, 01 word, 1x dual lanes |
| half_sel_i | input | 1 | Half select in half mode (0 low, 1 high) |
| imm_sel_i | input | 1 | 1: use imm_i, 0: use count_i |
| imm_i | input | 5 | Encoded immediate shift |
| count_i | input | 6 | Signed register shift count |
| sat_i | input | 1 | Saturate overflowing left shifts (register count only) |
| sticky_clr_i | input | 1 | Clears the sticky overflow flag |
| operand_i | input | 32 | Data to shift |
| result_o | output | 32 | Registered shift result |
| ovf_o | output | 1 | Overflow of the last valid operation |
| ovf_sticky_o | output | 1 | Accumulated overflow flag |

## Verification
Three kinds of internal fault show at the ports. A wrong direction or magnitude decode changes result_o on the cycle after the strobe for nearly every count in the sweep. A bad lane select or bad packing shows up as swapped or missing halves in the next result. A broken sticky path is harder to see, because it appears only after a later non-overflowing operation or a clear. For that reason the bench checks ovf_sticky_o after every operation against a running model, and it also runs targeted clear and clear-with-set sequences.

// File: rtl/shf_pkg.sv
package shf_pkg;
    parameter int SHF_CNT_W = 6;

    typedef enum logic [1:0] {
        MODE_HALF     = 2'b00,
        MODE_WORD     = 2'b01,
        MODE_DUAL     = 2'b10,
        MODE_DUAL_ALT = 2'b11
    } shf_mode_e;

    typedef struct packed {
        logic                 left;
        logic [SHF_CNT_W-1:0] mag;
    } shf_amt_t;
endpackage

// File: rtl/shf_amt_dec.sv
module shf_amt_dec
    import shf_pkg::*;
#(
    parameter int IMM_W    = 5,
    parameter int IMM_BIAS = 16
) (
    input  logic                 imm_sel_i,
    input  logic [IMM_W-1:0]     imm_i,
    input  logic [SHF_CNT_W-1:0] count_i,
    output shf_amt_t             amt_o
);
    localparam int LOW_W = $clog2(IMM_BIAS);

    always_comb begin
        if (imm_sel_i) begin
            amt_o.left = (imm_i > IMM_W'(IMM_BIAS));
            if (amt_o.left)
                amt_o.mag = SHF_CNT_W'(IMM_BIAS - int'(imm_i[LOW_W-1:0]));
            else
                amt_o.mag = SHF_CNT_W'(imm_i);
        end else begin
            amt_o.left = ($signed(count_i) > 0);
            if (amt_o.left)
                amt_o.mag = count_i;
            else
                amt_o.mag = SHF_CNT_W'(-count_i);
        end
    end
endmodule

// File: rtl/shf_lane.sv
module shf_lane
    import shf_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] opnd_i,
    input  shf_amt_t     amt_i,
    input  logic         sat_i,
    output logic [W-1:0] res_o,
    output logic         ovf_o
);
    localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_MAX = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] shl_d;
    logic [W-1:0] shr_d;

    always_comb begin
        shl_d = opnd_i << amt_i.mag;
        shr_d = $signed(opnd_i) >>> amt_i.mag;
        ovf_o = amt_i.left && (shl_d[W-1] != opnd_i[W-1]);
        if (!amt_i.left)
            res_o = shr_d;
        else if (ovf_o && sat_i)
            res_o = opnd_i[W-1] ? NEG_MAX : POS_MAX;
        else
            res_o = shl_d;
    end

    // R12
    always_comb begin
        if (sat_i && ovf_o)
            sat_sign_chk: assert (res_o[W-1] == opnd_i[W-1]);
    end
endmodule

// File: rtl/shift_ovf_unit.sv
module shift_ovf_unit
    import shf_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int IMM_W  = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   valid_i,
    input  logic [1:0]             width_sel_i,
    input  logic                   half_sel_i,
    input  logic                   imm_sel_i,
    input  logic [IMM_W-1:0]       imm_i,
    input  logic [SHF_CNT_W-1:0]   count_i,
    input  logic                   sat_i,
    input  logic                   sticky_clr_i,
    input  logic [2*HALF_W-1:0]    operand_i,
    output logic [2*HALF_W-1:0]    result_o,
    output logic                   ovf_o,
    output logic                   ovf_sticky_o
);
    localparam int WORD_W = 2 * HALF_W;
    localparam int LANES  = WORD_W / HALF_W;

    typedef struct packed {
        logic [WORD_W-1:0] res;
        logic              ovf;
        logic              sticky;
    } st_t;

    shf_amt_t  amt;
    shf_mode_e mode;
    logic      sat_eff;
    st_t       st_d, st_q;

    logic [HALF_W-1:0] lane_in  [LANES];
    logic [HALF_W-1:0] lane_res [LANES];
    logic [LANES-1:0]  lane_ovf;
    logic [WORD_W-1:0] word_res;
    logic              word_ovf;
    logic [WORD_W-1:0] res_now;
    logic              ovf_now;

    assign mode    = shf_mode_e'(width_sel_i);
    assign sat_eff = sat_i & ~imm_sel_i;

    shf_amt_dec #(.IMM_W(IMM_W), .IMM_BIAS(HALF_W)) u_dec (
        .imm_sel_i (imm_sel_i),
        .imm_i     (imm_i),
        .count_i   (count_i),
        .amt_o     (amt)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_sel
            assign lane_in[g] = (mode == MODE_HALF && half_sel_i)
                              ? operand_i[WORD_W-1 -: HALF_W]
                              : operand_i[HALF_W-1:0];
        end else begin : g_fix
            assign lane_in[g] = operand_i[g*HALF_W +: HALF_W];
        end
        shf_lane #(.W(HALF_W)) u_lane (
            .opnd_i (lane_in[g]),
            .amt_i  (amt),
            .sat_i  (sat_eff),
            .res_o  (lane_res[g]),
            .ovf_o  (lane_ovf[g])
        );
    end

    shf_lane #(.W(WORD_W)) u_word (
        .opnd_i (operand_i),
        .amt_i  (amt),
        .sat_i  (sat_eff),
        .res_o  (word_res),
        .ovf_o  (word_ovf)
    );

    always_comb begin
        res_now = '0;
        ovf_now = 1'b0;
        case (mode)
            MODE_HALF: begin
                res_now = {{(WORD_W-HALF_W){1'b0}}, lane_res[0]};
                ovf_now = lane_ovf[0];
            end
            MODE_WORD: begin
                res_now = word_res;
                ovf_now = word_ovf;
            end
            default: begin
                for (int i = 0; i < LANES; i++)
                    res_now[i*HALF_W +: HALF_W] = lane_res[i];
                ovf_now = |lane_ovf;
            end
        endcase

        st_d = st_q;
        if (valid_i) begin
            st_d.res = res_now;
            st_d.ovf = ovf_now;
        end
        st_d.sticky = (st_q.sticky & ~sticky_clr_i) | (valid_i & ovf_now);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_o     = st_q.res;
    assign ovf_o        = st_q.ovf;
    assign ovf_sticky_o = st_q.sticky;

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_sticky_o && !sticky_clr_i |=> ovf_sticky_o);
    // R6
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && ovf_now |=> ovf_o && ovf_sticky_o);
    // R5
    right_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && !amt.left |=> !ovf_o);
    // R13
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(result_o) && $stable(ovf_o));
    // R10
    half_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && mode == MODE_HALF |=> result_o[WORD_W-1:HALF_W] == '0);
endmodule

// File: tb/sim_shift_ovf_unit.sv
`timescale 1ns/1ps
module sim_shift_ovf_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [1:0]  width_sel_i = 2'b00;
    logic        half_sel_i = 1'b0;
    logic        imm_sel_i = 1'b0;
    logic [4:0]  imm_i = '0;
    logic [5:0]  count_i = '0;
    logic        sat_i = 1'b0;
    logic        sticky_clr_i = 1'b0;
    logic [31:0] operand_i = '0;
    logic [31:0] result_o;
    logic        ovf_o, ovf_sticky_o;

    int n_chk = 0, n_fail = 0;
    bit exp_sticky = 0;
    bit done = 0;

    always #4 clk = ~clk;

    shift_ovf_unit u0 (.*);

    function automatic logic [31:0] pat(int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'h7FFF_7FFF;
            3: return 32'h8000_8000;
            4: return 32'h0001_C000;
            5: return 32'h4000_FFFF;
            6: return 32'h1234_8765;
            default: return 32'hFFFF_0000;
        endcase
    endfunction

    // Arithmetic reference for one lane of width w.
    function automatic void ref_lane(input logic [31:0] v, input int w, input bit left,
                                     input int mag, input bit sat,
                                     output logic [31:0] r, output bit ov);
        longint mask = (64'sd1 <<< w) - 1;
        longint sv   = longint'(v) & mask;
        longint p;
        if (v[w-1]) sv = sv - (64'sd1 <<< w);
        if (!left) begin
            p  = sv >>> mag;
            ov = 0;
            r  = 32'(p & mask);
        end else begin
            p  = sv * (64'sd1 <<< mag);
            r  = 32'(p & mask);
            ov = (r[w-1] != v[w-1]);
            if (sat && ov) r = v[w-1] ? 32'(64'sd1 <<< (w-1)) : 32'(mask >>> 1);
        end
    endfunction

    function automatic void expect_op(input logic [1:0] ws, input bit hs, input bit isel,
                                      input logic [4:0] imm, input logic [5:0] cnt,
                                      input bit sat, input logic [31:0] op,
                                      output logic [31:0] r, output bit ov);
        bit left; int mag; bit se;
        logic [31:0] r0, r1; bit o0, o1;
        if (isel) begin
            left = (imm > 16);
            mag  = left ? 16 - int'(imm[3:0]) : int'(imm);
            se   = 0;
        end else begin
            int c = int'(cnt);
            if (c >= 32) c = c - 64;
            left = (c > 0);
            mag  = left ? c : -c;
            se   = sat;
        end
        if (ws == 2'b01) begin
            ref_lane(op, 32, left, mag, se, r, ov);
        end else if (ws == 2'b00) begin
            ref_lane(hs ? {16'h0, op[31:16]} : {16'h0, op[15:0]}, 16, left, mag, se, r0, o0);
            r = {16'h0, r0[15:0]}; ov = o0;
        end else begin
            ref_lane({16'h0, op[15:0]}, 16, left, mag, se, r0, o0);
            ref_lane({16'h0, op[31:16]}, 16, left, mag, se, r1, o1);
            r = {r1[15:0], r0[15:0]}; ov = o0 | o1;
        end
    endfunction

    task automatic check(input string tag, input logic [31:0] ra, input logic [31:0] re,
                         input bit oa, input bit oe, input bit sa, input bit se);
        n_chk++;
        if (ra !== re || oa !== oe || sa !== se) begin
            n_fail++;
            $display("FAIL %s: act res=%h ovf=%0b sticky=%0b exp res=%h ovf=%0b sticky=%0b",
                     tag, ra, oa, sa, re, oe, se);
        end
    endtask

    task automatic do_op(input string tag, input logic [1:0] ws, input bit hs, input bit isel,
                         input logic [4:0] imm, input logic [5:0] cnt, input bit sat,
                         input logic [31:0] op, input bit clr);
        logic [31:0] er; bit eo;
        expect_op(ws, hs, isel, imm, cnt, sat, op, er, eo);
        @(negedge clk);
        width_sel_i = ws; half_sel_i = hs; imm_sel_i = isel; imm_i = imm;
        count_i = cnt; sat_i = sat; operand_i = op; sticky_clr_i = clr; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0; sticky_clr_i = 1'b0;
        exp_sticky = eo | (exp_sticky & ~clr);
        check(tag, result_o, er, ovf_o, eo, ovf_sticky_o, exp_sticky);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog R13: act=hung exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] hr; bit ho;
        repeat (3) @(negedge clk);
        check("R1 reset", result_o, 32'h0, ovf_o, 1'b0, ovf_sticky_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corners
        do_op("R3 right by 32 fills sign", 2'b01, 0, 0, 0, 6'h20, 0, 32'h8000_0001, 0);
        do_op("R4 left 16 on half gives zero", 2'b00, 0, 0, 0, 6'd16, 0, 32'h0000_0001, 0);
        do_op("R5 sign change sets ovf", 2'b00, 0, 0, 0, 6'd1, 0, 32'h0000_4000, 0);
        do_op("R7 no-ovf op clears ovf", 2'b00, 0, 0, 0, 6'd1, 0, 32'h0000_0001, 0);
        do_op("R6 clear sticky", 2'b00, 0, 0, 0, 6'd0, 0, 32'h0000_0001, 1);
        do_op("R6 set", 2'b01, 0, 0, 0, 6'd1, 0, 32'h4000_0000, 0);
        do_op("R6 set beats clear", 2'b01, 0, 0, 0, 6'd1, 0, 32'h4000_0000, 1);
        do_op("R9 bit31 sign", 2'b01, 0, 0, 0, 6'd16, 0, 32'h0000_8000, 0);
        do_op("R8 lane1 only ovf", 2'b10, 0, 0, 0, 6'd1, 0, 32'h4000_0001, 0);
        do_op("R12 sat negative", 2'b00, 1, 0, 0, 6'd4, 1, 32'h8765_0000, 0);
        do_op("R11 imm 17 left 15", 2'b00, 0, 1, 5'd17, 6'd0, 0, 32'h0000_0001, 0);
        do_op("R11 imm 16 right 16", 2'b00, 0, 1, 5'd16, 6'd5, 1, 32'h0000_8000, 0);

        // R13: inputs change without valid
        hr = result_o; ho = ovf_o;
        @(negedge clk);
        operand_i = 32'hDEAD_BEEF; count_i = 6'd3; width_sel_i = 2'b01;
        repeat (3) @(negedge clk);
        check("R13 hold", result_o, hr, ovf_o, ho, ovf_sticky_o, exp_sticky);

        // Sweep register counts (R2..R10, R12)
        for (int ws = 0; ws < 3; ws++)
            for (int hs = 0; hs < 2; hs++)
                for (int c = 0; c < 64; c++)
                    for (int s = 0; s < 2; s++)
                        for (int p = 0; p < 8; p++)
                            do_op(s ? "R12 sweep sat" : (ws == 0 ? "R10 sweep half" :
                                  (ws == 1 ? "R9 sweep word" : "R8 sweep dual")),
                                  2'(ws), 1'(hs), 0, 5'd0, 6'(c), 1'(s), pat(p), 0);

        // Sweep immediates (R11), sat ignored
        for (int ws = 0; ws < 3; ws++)
            for (int im = 0; im < 32; im++)
                for (int s = 0; s < 2; s++)
                    for (int p = 0; p < 8; p++)
                        do_op("R11 sweep imm", 2'(ws), 1'(p & 1), 1, 5'(im),
                              6'(im * 3), 1'(s), pat(p), 0);

        // R2: extremes of the 6-bit count
        do_op("R2 count -32", 2'b01, 0, 0, 0, 6'b100000, 0, 32'h1234_5678, 0);
        do_op("R2 count +31", 2'b01, 0, 0, 0, 6'b011111, 0, 32'h0000_0001, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule